// File: doc/BRIEF.md
# Serial Management Register File for an Ethernet Transceiver Port

This block is the management slave of one transceiver port. It watches the two-wire management bus (a clock driven by the station controller and a shared bidirectional data line) and decodes each frame. A frame is a run of at least 32 ones, a start pattern 0 then 1, a two-bit opcode, the 5-bit port address, the 5-bit register number, a two-bit turnaround and a 16-bit data word sent most significant bit first. It answers only frames that carry its own port address. It keeps the seven standard management registers: control, status, two identifier words, the local ability advertisement, the partner ability word and the negotiation expansion word.

Both bus wires are brought into the block's single clock domain through synchronizers. Each rising edge of the management clock is detected and acted on there. The data line is split into an input, an output value and an output enable for an external tri-state pad. The port core drives the event inputs: link state, jabber events, negotiation complete, negotiated duplex, and a strobe with a newly received partner code word. The control outputs (software reset in progress, speed, duplex and negotiation enable) are registered.

Several register bits behave in a special way. A software reset bit clears itself and blocks control writes while it runs. The link bit latches low, and two event bits latch high and clear when read. Next-page related bits always read zero.

Top module: `mdio_regfile`

## Requirements
- R1: After the synchronous reset `rst`, registers 0 to 6 read 0x3100, 0x0F49, 0x001C, 0xC883, 0x05E1, 0x0001 and 0x0000, with `link_up_i`, `an_complete_i` low and `an_duplex_i` high. The outputs are `speed_o`=1, `an_en_o`=1, `duplex_o`=1, `sw_rst_o`=0 and `mdio_oe`=0.
- R2: A read frame uses opcode bits 1,0 and a write frame uses 0,1, both after 32 ones and the start bits 0,1. On a read, `mdio_oe` stays low during the first turnaround bit. It then drives 0 in the second turnaround bit, drives the 16 data bits MSB first, and releases after the last one. `mdio_oe` never rises during a write.
- R3: A frame whose 5-bit address differs from `phy_addr_i` keeps `mdio_oe` low for the whole frame, and a write inside it changes no register.
- R4: Writing a 1 to control bit 15 returns control to 0x3100 and advertisement to 0x05E1. It holds `sw_rst_o` high for exactly RST_CYCLES clocks (default 1500), and control bit 15 reads 1 during that time. The bit then clears by itself. A control write with bit 15 at 0 starts no reset.
- R5: While the software reset runs, control-register writes are ignored.
- R6: Status bit 2 reads 1 only if the link has stayed up since the previous status read. A drop of `link_up_i` makes it read 0 once, even if the link is back. Status bit 5 follows `an_complete_i`.
- R7: A pulse on `jabber_evt_i` sets status bit 1. The bit reads 1 on the next status read and 0 on the read after that.
- R8: In the advertisement register (4), bits 15 and 14 always read 0 and bits 13..0 read back as written.
- R9: A pulse on `lcw_rcv_i` loads `lp_word_i` into register 5 and sets bit 1 of register 6. That bit clears after one read of register 6. Bits 2 and 0 of register 6 always read 0.
- R10: With control bit 12 (negotiation enable) at 1, control bit 8 and `duplex_o` show `an_duplex_i`. With it at 0, they show the value last written to bit 8.
- R11: `speed_o` and `an_en_o` follow control bits 13 and 12. Control bits 14, 11, 10 read back as written, and bits 9 and 7..0 read 0.
- R12: Registers 7 to 31 read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the management clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_i | input | 1 | Management clock from the controller |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data value driven during read replies |
| mdio_oe | output | 1 | Pad output enable; 0 means released |
| phy_addr_i | input | 5 | Port address this slave answers to |
| link_up_i | input | 1 | Current link state from the port core |
| jabber_evt_i | input | 1 | One-clock jabber event |
| an_complete_i | input | 1 | Negotiation finished |
| an_duplex_i | input | 1 | Negotiated duplex (1 = full) |
| lcw_rcv_i | input | 1 | One-clock strobe: partner code word received and acknowledged |
| lp_word_i | input | 16 | Partner code word loaded on `lcw_rcv_i` |
| sw_rst_o | output | 1 | Software reset in progress |
| speed_o | output | 1 | Speed select (1 = 100 Mb/s) |
| duplex_o | output | 1 | Effective duplex (1 = full) |
| an_en_o | output | 1 | Negotiation enable |

## Verification
The hardest case to reach from the ports is a control write that lands while the software reset is still running. A write frame takes far longer than a few clocks, so the reset window is long by default. The stimulus starts the reset, reads control back while the reset is running, and sends a control write immediately after that read. Both frames end inside the window. The checks then confirm that the write left no trace once `sw_rst_o` falls. The latched link bit needs a link drop between two status reads, which the stimulus produces by pulsing `link_up_i` low with no frame in flight.

// File: rtl/mdio_regfile_pkg.sv
package mdio_regfile_pkg;

  typedef enum logic [2:0] {
    FS_PRE,
    FS_START,
    FS_HDR,
    FS_TA,
    FS_DATA
  } frame_st_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [4:0] RA_CTRL = 5'd0;
  localparam logic [4:0] RA_STAT = 5'd1;
  localparam logic [4:0] RA_ID_H = 5'd2;
  localparam logic [4:0] RA_ID_L = 5'd3;
  localparam logic [4:0] RA_ADV  = 5'd4;
  localparam logic [4:0] RA_LPA  = 5'd5;
  localparam logic [4:0] RA_EXP  = 5'd6;

  localparam logic [14:0] CTRL_DEF   = 15'h3100;
  localparam logic [14:0] CTRL_WMASK = 15'h7D00;
  localparam logic [15:0] STAT_FIX   = 16'h0F49;
  localparam logic [13:0] ADV_DEF    = 14'h05E1;
  localparam logic [15:0] LPA_DEF    = 16'h0001;

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic bit_rise,
  output logic bit_val
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] mdc_sr;
  logic [LAST:0] dat_sr;
  logic          mdc_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          mdc_sr <= '0;
          dat_sr <= '1;
        end else begin
          mdc_sr <= mdc_i;
          dat_sr <= mdio_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          mdc_sr <= '0;
          dat_sr <= '1;
        end else begin
          mdc_sr <= {mdc_sr[LAST-1:0], mdc_i};
          dat_sr <= {dat_sr[LAST-1:0], mdio_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) mdc_prev <= 1'b0;
    else     mdc_prev <= mdc_sr[LAST];
  end

  assign bit_rise = mdc_sr[LAST] & ~mdc_prev;
  assign bit_val  = dat_sr[LAST];
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_regfile_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bit_rise,
  input  logic        bit_val,
  input  logic [4:0]  phy_addr,
  input  logic [15:0] rdata,
  output logic        rd_stb,
  output logic        wr_stb,
  output logic [4:0]  reg_addr,
  output logic [15:0] wdata,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam logic [PW-1:0] PRE_MAX = PW'(PRE_LEN);

  frame_st_e    st;
  logic [PW-1:0] pre_cnt;
  logic [3:0]   bit_cnt;
  logic [11:0]  hdr_q;
  logic [15:0]  sh_q;
  logic         do_rd;
  logic         do_wr;

  logic [11:0] hdr_nx;
  logic        hit;
  assign hdr_nx = {hdr_q[10:0], bit_val};
  assign hit    = (hdr_nx[9:5] == phy_addr);
  assign wdata  = sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_PRE;
      pre_cnt  <= '0;
      bit_cnt  <= '0;
      hdr_q    <= '0;
      sh_q     <= '0;
      do_rd    <= 1'b0;
      do_wr    <= 1'b0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      reg_addr <= '0;
      mdio_o   <= 1'b0;
      mdio_oe  <= 1'b0;
    end else begin
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
      if (rd_stb) sh_q <= rdata;
      if (bit_rise) begin
        unique case (st)
          FS_PRE: begin
            if (bit_val) begin
              if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
            end else begin
              if (pre_cnt == PRE_MAX) st <= FS_START;
              pre_cnt <= '0;
            end
          end
          FS_START: begin
            bit_cnt <= '0;
            st      <= bit_val ? FS_HDR : FS_PRE;
          end
          FS_HDR: begin
            hdr_q   <= hdr_nx;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 4'd11) begin
              do_rd    <= hit && (hdr_nx[11:10] == OP_RD);
              do_wr    <= hit && (hdr_nx[11:10] == OP_WR);
              rd_stb   <= hit && (hdr_nx[11:10] == OP_RD);
              reg_addr <= hdr_nx[4:0];
              bit_cnt  <= '0;
              st       <= FS_TA;
            end
          end
          FS_TA: begin
            if (bit_cnt == 4'd0) begin
              bit_cnt <= 4'd1;
              if (do_rd) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              bit_cnt <= '0;
              st      <= FS_DATA;
              if (do_rd) begin
                mdio_o <= sh_q[15];
                sh_q   <= {sh_q[14:0], 1'b0};
              end
            end
          end
          FS_DATA: begin
            bit_cnt <= bit_cnt + 1'b1;
            if (do_rd) begin
              mdio_o <= sh_q[15];
              sh_q   <= {sh_q[14:0], 1'b0};
            end else begin
              sh_q <= {sh_q[14:0], bit_val};
            end
            if (bit_cnt == 4'd15) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b0;
              wr_stb  <= do_wr;
              pre_cnt <= '0;
              bit_cnt <= '0;
              st      <= FS_PRE;
            end
          end
          default: st <= FS_PRE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import mdio_regfile_pkg::*;
#(
  parameter int          RST_CYCLES = 1500,
  parameter logic [15:0] ID_HI      = 16'h001C,
  parameter logic [15:0] ID_LO      = 16'hC883
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [4:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        link_up_i,
  input  logic        jabber_evt_i,
  input  logic        an_complete_i,
  input  logic        an_duplex_i,
  input  logic        lcw_rcv_i,
  input  logic [15:0] lp_word_i,
  output logic        sw_rst_o,
  output logic        speed_o,
  output logic        duplex_o,
  output logic        an_en_o
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [RW-1:0] RST_LOAD = RW'(RST_CYCLES);

  logic [RW-1:0] rst_cnt;
  logic [14:0]   ctrl_q;
  logic [13:0]   adv_q;
  logic [15:0]   lpa_q;
  logic          link_lat;
  logic          jab_lat;
  logic          page_lat;

  logic busy, dup_eff, rd_stat, rd_exp, wr_ctrl, wr_adv;
  assign busy    = (rst_cnt != '0);
  assign dup_eff = ctrl_q[12] ? an_duplex_i : ctrl_q[8];
  assign rd_stat = rd_stb && (addr == RA_STAT);
  assign rd_exp  = rd_stb && (addr == RA_EXP);
  assign wr_ctrl = wr_stb && (addr == RA_CTRL) && !busy;
  assign wr_adv  = wr_stb && (addr == RA_ADV);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_cnt  <= '0;
      ctrl_q   <= CTRL_DEF;
      adv_q    <= ADV_DEF;
      lpa_q    <= LPA_DEF;
      link_lat <= 1'b0;
      jab_lat  <= 1'b0;
      page_lat <= 1'b0;
    end else begin
      if (busy) rst_cnt <= rst_cnt - 1'b1;
      if (wr_ctrl) begin
        if (wdata[15]) begin
          ctrl_q  <= CTRL_DEF;
          adv_q   <= ADV_DEF;
          rst_cnt <= RST_LOAD;
        end else begin
          ctrl_q <= wdata[14:0] & CTRL_WMASK;
        end
      end else if (wr_adv) begin
        adv_q <= wdata[13:0];
      end
      if (!link_up_i)   link_lat <= 1'b0;
      else if (rd_stat) link_lat <= 1'b1;
      if (jabber_evt_i) jab_lat <= 1'b1;
      else if (rd_stat) jab_lat <= 1'b0;
      if (lcw_rcv_i) begin
        page_lat <= 1'b1;
        lpa_q    <= lp_word_i;
      end else if (rd_exp) begin
        page_lat <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr)
      RA_CTRL: rdata = {busy, ctrl_q[14:9], dup_eff, ctrl_q[7:0]};
      RA_STAT: rdata = STAT_FIX | {10'b0, an_complete_i, 2'b0, link_lat, jab_lat, 1'b0};
      RA_ID_H: rdata = ID_HI;
      RA_ID_L: rdata = ID_LO;
      RA_ADV:  rdata = {2'b00, adv_q};
      RA_LPA:  rdata = lpa_q;
      RA_EXP:  rdata = {14'b0, page_lat, 1'b0};
      default: rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_rst_o <= 1'b0;
      speed_o  <= CTRL_DEF[13];
      an_en_o  <= CTRL_DEF[12];
      duplex_o <= CTRL_DEF[8];
    end else begin
      sw_rst_o <= busy;
      speed_o  <= ctrl_q[13];
      an_en_o  <= ctrl_q[12];
      duplex_o <= dup_eff;
    end
  end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int          PRE_LEN     = 32,
  parameter int          SYNC_STAGES = 2,
  parameter int          RST_CYCLES  = 1500,
  parameter logic [15:0] ID_HI       = 16'h001C,
  parameter logic [15:0] ID_LO       = 16'hC883
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mdc_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic [4:0]  phy_addr_i,
  input  logic        link_up_i,
  input  logic        jabber_evt_i,
  input  logic        an_complete_i,
  input  logic        an_duplex_i,
  input  logic        lcw_rcv_i,
  input  logic [15:0] lp_word_i,
  output logic        sw_rst_o,
  output logic        speed_o,
  output logic        duplex_o,
  output logic        an_en_o
);
  logic        bit_rise, bit_val;
  logic        rd_stb, wr_stb;
  logic [4:0]  reg_addr;
  logic [15:0] wdata, rdata;

  mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .mdc_i(mdc_i), .mdio_i(mdio_i),
    .bit_rise(bit_rise), .bit_val(bit_val)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst(rst), .bit_rise(bit_rise), .bit_val(bit_val),
    .phy_addr(phy_addr_i), .rdata(rdata),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .reg_addr(reg_addr), .wdata(wdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mgmt_regs #(.RST_CYCLES(RST_CYCLES), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr(reg_addr), .wdata(wdata), .rdata(rdata),
    .link_up_i(link_up_i), .jabber_evt_i(jabber_evt_i),
    .an_complete_i(an_complete_i), .an_duplex_i(an_duplex_i),
    .lcw_rcv_i(lcw_rcv_i), .lp_word_i(lp_word_i),
    .sw_rst_o(sw_rst_o), .speed_o(speed_o), .duplex_o(duplex_o), .an_en_o(an_en_o)
  );
endmodule

// File: rtl/mdio_regfile_chk.sv
module mdio_regfile_chk #(
  parameter int RST_CYCLES = 1500
) (
  input logic clk,
  input logic rst,
  input logic mdio_o,
  input logic mdio_oe,
  input logic wr_stb,
  input logic sw_rst_o,
  input logic speed_o,
  input logic an_en_o
);
  int unsigned hi_run;

  always_ff @(posedge clk) begin
    if (rst)           hi_run <= 0;
    else if (sw_rst_o) hi_run <= hi_run + 1;
    else               hi_run <= 0;
  end

  // R1: outputs leave reset at their default values
  p_reset_out_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (speed_o && an_en_o && !sw_rst_o && !mdio_oe));

  // R2: the reply starts by driving a 0 in the second turnaround bit
  p_ta_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  // R2: a completed write is never accompanied by a driven line
  p_wr_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !mdio_oe);

  // R4: the reset window never exceeds its length
  p_rst_len_r4: assert property (@(posedge clk) disable iff (rst)
    sw_rst_o |-> (hi_run < RST_CYCLES));

  // R5: control outputs hold still while the reset runs
  p_rst_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (sw_rst_o && $past(sw_rst_o)) |-> ($stable(speed_o) && $stable(an_en_o)));
endmodule

bind mdio_regfile mdio_regfile_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .wr_stb(wr_stb),
  .sw_rst_o(sw_rst_o), .speed_o(speed_o), .an_en_o(an_en_o)
);

// File: tb/mdio_regfile_bench.sv
module mdio_regfile_bench;
  localparam int         HALF  = 4;
  localparam logic [4:0] ME    = 5'd5;
  localparam int         RST_N = 1500;

  logic        clk = 1'b0, rst = 1'b1;
  logic        mdc = 1'b0, mdio_in = 1'b1;
  logic        mdio_o, mdio_oe;
  logic        link_up = 1'b0, jab_evt = 1'b0, an_cmp = 1'b0, an_dup = 1'b1;
  logic        lcw = 1'b0;
  logic [15:0] lp_word = 16'h0;
  logic        sw_rst_o, speed_o, duplex_o, an_en_o;

  int total = 0, bad = 0;
  int rst_hi = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) if (sw_rst_o) rst_hi <= rst_hi + 1;

  mdio_regfile u_mdio_regfile (
    .clk(clk), .rst(rst), .mdc_i(mdc), .mdio_i(mdio_in),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .phy_addr_i(ME),
    .link_up_i(link_up), .jabber_evt_i(jab_evt), .an_complete_i(an_cmp),
    .an_duplex_i(an_dup), .lcw_rcv_i(lcw), .lp_word_i(lp_word),
    .sw_rst_o(sw_rst_o), .speed_o(speed_o), .duplex_o(duplex_o), .an_en_o(an_en_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mbit(input logic b, output logic so, output logic soe);
    mdio_in = b;
    mdc = 1'b0;
    repeat (HALF) @(negedge clk);
    so = mdio_o;
    soe = mdio_oe;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, output logic [15:0] rv,
                       output logic shape_ok, output logic any_oe);
    logic so, soe;
    rv = '0; shape_ok = 1'b1; any_oe = 1'b0;
    for (int i = 0; i < 32; i++) begin mbit(1'b1, so, soe); any_oe |= soe; end
    mbit(1'b0, so, soe); any_oe |= soe;
    mbit(1'b1, so, soe); any_oe |= soe;
    mbit(rd, so, soe);   any_oe |= soe;
    mbit(!rd, so, soe);  any_oe |= soe;
    for (int i = 4; i >= 0; i--) begin mbit(pa[i], so, soe); any_oe |= soe; end
    for (int i = 4; i >= 0; i--) begin mbit(ra[i], so, soe); any_oe |= soe; end
    mbit(1'b1, so, soe); any_oe |= soe;
    if (soe) shape_ok = 1'b0;
    mbit(!rd, so, soe); any_oe |= soe;
    if (rd && !(soe && !so)) shape_ok = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      mbit(rd ? 1'b1 : wd[i], so, soe); any_oe |= soe;
      rv[i] = so;
      if (rd && !soe) shape_ok = 1'b0;
    end
    mbit(1'b1, so, soe);
    if (soe) shape_ok = 1'b0;
    if (!rd && any_oe) shape_ok = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] ra, output logic [15:0] v);
    logic ok, aoe;
    frame(1'b1, ME, ra, 16'h0, v, ok, aoe);
    chk("R2 read frame shape", {15'b0, ok}, 16'h1);
  endtask

  task automatic wr_reg(input logic [4:0] ra, input logic [15:0] d);
    logic [15:0] v;
    logic ok, aoe;
    frame(1'b0, ME, ra, d, v, ok, aoe);
    chk("R2 write keeps line released", {15'b0, aoe}, 16'h0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 sw_rst_o after reset", {15'b0, sw_rst_o}, 16'h0);
    chk("R1 speed_o after reset", {15'b0, speed_o}, 16'h1);
    chk("R1 an_en_o after reset", {15'b0, an_en_o}, 16'h1);
    chk("R1 duplex_o after reset", {15'b0, duplex_o}, 16'h1);
    chk("R1 mdio_oe after reset", {15'b0, mdio_oe}, 16'h0);
  endtask

  task automatic t_defaults;
    logic [15:0] v;
    logic [15:0] exp [7] = '{16'h3100, 16'h0F49, 16'h001C, 16'hC883, 16'h05E1, 16'h0001, 16'h0000};
    for (int r = 0; r < 7; r++) begin
      rd_reg(5'(r), v);
      chk($sformatf("R1 default of register %0d", r), v, exp[r]);
    end
  endtask

  task automatic t_unimpl;
    logic [15:0] v;
    rd_reg(5'd7, v);  chk("R12 register 7", v, 16'h0000);
    rd_reg(5'd31, v); chk("R12 register 31", v, 16'h0000);
  endtask

  task automatic t_adv;
    logic [15:0] v;
    wr_reg(5'd4, 16'hFFFF);
    rd_reg(5'd4, v); chk("R8 advert bits 15,14 read 0", v, 16'h3FFF);
    wr_reg(5'd4, 16'h0A5A);
    rd_reg(5'd4, v); chk("R8 advert readback", v, 16'h0A5A);
  endtask

  task automatic t_foreign;
    logic [15:0] v;
    logic ok, aoe;
    frame(1'b1, ME ^ 5'd1, 5'd2, 16'h0, v, ok, aoe);
    chk("R3 foreign read keeps line released", {15'b0, aoe}, 16'h0);
    frame(1'b0, ME ^ 5'd16, 5'd4, 16'h1234, v, ok, aoe);
    chk("R3 foreign write keeps line released", {15'b0, aoe}, 16'h0);
    rd_reg(5'd4, v); chk("R3 foreign write ignored", v, 16'h0A5A);
  endtask

  task automatic t_ctrl;
    logic [15:0] v;
    wr_reg(5'd0, 16'h4F80);
    rd_reg(5'd0, v); chk("R11 ctrl readback masks bits 9,7..0", v, 16'h4D00);
    chk("R11 speed_o low", {15'b0, speed_o}, 16'h0);
    chk("R11 an_en_o low", {15'b0, an_en_o}, 16'h0);
    chk("R10 duplex_o follows written bit", {15'b0, duplex_o}, 16'h1);
    wr_reg(5'd0, 16'h0000);
    rd_reg(5'd0, v); chk("R10 duplex written 0", v, 16'h0000);
    chk("R10 duplex_o 0", {15'b0, duplex_o}, 16'h0);
    wr_reg(5'd0, 16'h1000);
    rd_reg(5'd0, v); chk("R10 negotiated duplex shown", v, 16'h1100);
    chk("R10 duplex_o negotiated", {15'b0, duplex_o}, 16'h1);
    chk("R11 an_en_o high", {15'b0, an_en_o}, 16'h1);
    an_dup = 1'b0;
    rd_reg(5'd0, v); chk("R10 negotiated half duplex", v, 16'h1000);
    chk("R10 duplex_o half", {15'b0, duplex_o}, 16'h0);
    an_dup = 1'b1;
  endtask

  task automatic t_swreset;
    logic [15:0] v;
    int start;
    wr_reg(5'd4, 16'h0021);
    start = rst_hi;
    wr_reg(5'd0, 16'h8000);
    chk("R4 sw_rst_o active", {15'b0, sw_rst_o}, 16'h1);
    rd_reg(5'd0, v); chk("R4 bit 15 reads 1 during reset", v, 16'hB100);
    wr_reg(5'd0, 16'h0000);
    chk("R5 still inside reset window", {15'b0, sw_rst_o}, 16'h1);
    while (sw_rst_o) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R4 reset length", 16'(rst_hi - start), 16'(RST_N));
    rd_reg(5'd0, v); chk("R5 write during reset ignored", v, 16'h3100);
    chk("R5 speed_o kept", {15'b0, speed_o}, 16'h1);
    rd_reg(5'd4, v); chk("R4 advert restored", v, 16'h05E1);
    start = rst_hi;
    wr_reg(5'd0, 16'h3100);
    repeat (8) @(negedge clk);
    chk("R4 bit 15 zero starts no reset", 16'(rst_hi - start), 16'h0);
  endtask

  task automatic t_link;
    logic [15:0] v;
    link_up = 1'b1; an_cmp = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(5'd1, v); chk("R6 first read after link up", v, 16'h0F69);
    rd_reg(5'd1, v); chk("R6 link steady", v, 16'h0F6D);
    link_up = 1'b0;
    repeat (5) @(negedge clk);
    link_up = 1'b1;
    repeat (5) @(negedge clk);
    rd_reg(5'd1, v); chk("R6 drop latched low", v, 16'h0F69);
    rd_reg(5'd1, v); chk("R6 recovers after read", v, 16'h0F6D);
  endtask

  task automatic t_jabber;
    logic [15:0] v;
    jab_evt = 1'b1; @(negedge clk); jab_evt = 1'b0;
    rd_reg(5'd1, v); chk("R7 jabber set", v, 16'h0F6F);
    rd_reg(5'd1, v); chk("R7 jabber cleared on read", v, 16'h0F6D);
  endtask

  task automatic t_page;
    logic [15:0] v;
    lp_word = 16'h45E1;
    lcw = 1'b1; @(negedge clk); lcw = 1'b0;
    rd_reg(5'd5, v); chk("R9 partner word loaded", v, 16'h45E1);
    rd_reg(5'd6, v); chk("R9 page received set", v, 16'h0002);
    rd_reg(5'd6, v); chk("R9 page received cleared", v, 16'h0000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    t_defaults;
    t_unimpl;
    t_adv;
    t_foreign;
    t_ctrl;
    t_swreset;
    t_link;
    t_jabber;
    t_page;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule